// File: doc/BRIEF.md
# Code Prefetch Unit

This block sits between instruction memory and an execution stage and lets the two run at their own pace. A fetch sequencer reads code bytes from consecutive addresses and places them in a small byte queue. It starts a new read whenever the queue has a free slot and no read is outstanding. The execute side takes bytes from the head of the queue through a valid/ready pop port. It waits whenever the queue is empty, and the fetch side waits whenever the queue is full.

When the execute side takes a branch, it raises `redirect` together with the target address. In the next cycle the queue is empty and the fetch address holds the target. A read that is still outstanding at that moment is allowed to finish, but its byte is thrown away. A byte that returns in the same cycle as the redirect is thrown away too. Fetching then resumes at the target.

The memory port has one request pulse per read and returns one byte with a valid strobe some cycles later. The block does not depend on a fixed latency. Reset is asynchronous and active low. The caller releases it synchronously to `clk`.

Top module: `code_prefetch_unit`

## Requirements
- R1: While reset is held, `pop_valid` is 0 and `mem_addr` equals the parameter `RESET_ADDR` (default 0).
- R2: Bytes leave the pop port in the order of their addresses. `mem_addr` advances by one for every byte written into the queue, so after six accepted bytes from reset it reads 6.
- R3: `mem_req` is raised only when no read is outstanding and the queue holds fewer than `DEPTH` (default 6) bytes. With the queue full, `mem_req` stays 0.
- R4: A pop request while the queue is empty has no effect. The next byte delivered is still the next address in sequence.
- R5: One cycle after `redirect` is sampled high, `pop_valid` is 0 and `mem_addr` equals the sampled `redirect_addr`. This holds also when the queue was full.
- R6: A byte belonging to a read that was outstanding when a redirect was sampled never reaches the queue. This includes a byte whose `mem_rvalid` coincides with the redirect. The first byte popped after a redirect is the byte at the target address.
- R7: A pop request in the same cycle as a redirect is ignored. After the flush, the target byte is the first byte delivered.
- R8: A byte returned with `mem_rvalid` is visible at `pop_data` with `pop_valid` high in the following cycle. With a 4-cycle memory, the first byte after reset release is visible at the 5th falling edge.
- R9: Pushing and popping in the same cycle keeps the queue order intact while the consumer streams bytes continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request strobe, one cycle per read |
| mem_addr | output | ADDR_W | Address of the byte being fetched, held while the read is outstanding |
| mem_rdata | input | 8 | Returned code byte |
| mem_rvalid | input | 1 | `mem_rdata` valid this cycle; one strobe per request |
| pop_ready | input | 1 | Execute side takes the head byte this cycle |
| pop_valid | output | 1 | Queue holds at least one byte |
| pop_data | output | 8 | Byte at the head of the queue |
| redirect | input | 1 | Taken branch: flush and restart at `redirect_addr` |
| redirect_addr | input | ADDR_W | Branch target address |

## Verification
The bench's memory model answers a request 4 cycles after the edge that sampled it. It sets `mem_rvalid` for the cycle before that 4th edge. The first byte therefore shows on the pop port at the 5th falling edge after reset release, and the queue is full at the 30th. The bench samples there and asserts nothing in between. A redirect or pop is driven at a falling edge and takes effect at the next rising edge, so its outcome (`pop_valid` low, `mem_addr` at the target) is read at the following falling edge. The same-cycle redirect case is hit by watching the model's own `mem_rvalid` strobe shortly after a falling edge and raising `redirect` before the next rising edge.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] code_byte_t;
endpackage

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  code_byte_t                   wdata,
  input  logic                         pop,
  output code_byte_t                   rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  code_byte_t       store [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign count   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = store[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = bump(wr_q);
      if (do_pop)  rd_n = bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + CNT_W'(1);
        2'b01:   cnt_n = cnt_q - CNT_W'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) store[wr_q] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R3
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push && !flush) |=> (count == $past(count) - CNT_W'(1))); // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R5
endmodule

// File: rtl/pfq_fetch_seq.sv
module pfq_fetch_seq #(
  parameter int unsigned       ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              room,
  input  logic              mem_rvalid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              push
);
  logic              busy_q, busy_n;
  logic              drop_q, drop_n;
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic              accept;

  assign mem_req  = !busy_q && room;
  assign accept   = busy_q && mem_rvalid;
  assign push     = accept && !drop_q && !redirect;
  assign mem_addr = pc_q;

  always_comb begin
    busy_n = busy_q;
    if (mem_req)     busy_n = 1'b1;
    else if (accept) busy_n = 1'b0;

    drop_n = drop_q;
    if (redirect)    drop_n = mem_req || (busy_q && !mem_rvalid);
    else if (accept) drop_n = 1'b0;

    pc_n = pc_q;
    if (redirect)  pc_n = redirect_addr;
    else if (push) pc_n = pc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      pc_q   <= RESET_ADDR;
    end else begin
      busy_q <= busy_n;
      drop_q <= drop_n;
      pc_q   <= pc_n;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R2
  AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (mem_addr == $past(redirect_addr))); // R5
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R3
endmodule

// File: rtl/code_prefetch_unit.sv
module code_prefetch_unit
  import pfq_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter int unsigned       DEPTH      = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rvalid,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [7:0]        pop_data,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic             q_push, q_empty, q_full, q_pop;
  logic [CNT_W-1:0] q_count;
  code_byte_t       q_head;

  assign q_pop     = pop_ready && !redirect;
  assign pop_valid = !q_empty;
  assign pop_data  = q_head;

  pfq_fetch_seq #(
    .ADDR_W    (ADDR_W),
    .RESET_ADDR(RESET_ADDR)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .redirect     (redirect),
    .redirect_addr(redirect_addr),
    .room         (!q_full),
    .mem_rvalid   (mem_rvalid),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .push         (q_push)
  );

  pfq_byte_fifo #(
    .DEPTH(DEPTH)
  ) u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(redirect),
    .push (q_push),
    .wdata(mem_rdata),
    .pop  (q_pop),
    .rdata(q_head),
    .count(q_count),
    .empty(q_empty),
    .full (q_full)
  );

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CNT_W'(DEPTH)) |-> !mem_req); // R3
  AST_REDIRECT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !pop_valid); // R5
  AST_RVALID_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && !q_pop) |=> pop_valid); // R8
endmodule

// File: tb/code_prefetch_unit_test.sv
module code_prefetch_unit_test;
  localparam int AW  = 16;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;
  logic          mem_rvalid;
  logic          pop_ready;
  logic          pop_valid;
  logic [7:0]    pop_data;
  logic          redirect;
  logic [AW-1:0] redirect_addr;

  int checks = 0;
  int errors = 0;

  code_prefetch_unit uut (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .redirect(redirect), .redirect_addr(redirect_addr)
  );

  initial forever #5 clk = ~clk;

  function automatic logic [7:0] code_at(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: answers each request LAT edges after the edge that took it
  initial begin
    logic [AW-1:0] a;
    mem_rvalid = 1'b0;
    mem_rdata  = 8'h00;
    @(posedge rst_n);
    forever begin
      mem_rvalid = 1'b0;
      if (mem_req) begin
        a = mem_addr;
        repeat (LAT) @(negedge clk);
        mem_rdata  = code_at(a);
        mem_rvalid = 1'b1;
      end
      @(negedge clk);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; waits for a byte, takes it, returns at a falling edge
  task automatic pop_expect(input logic [AW-1:0] a, input string tag);
    while (!pop_valid) @(negedge clk);
    chk(pop_data == code_at(a), tag, 32'(pop_data), 32'(code_at(a)));
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(pop_valid == 1'b0, "R1 pop_valid in reset", 32'(pop_valid), 32'd0);
    chk(mem_addr == '0, "R1 mem_addr in reset", 32'(mem_addr), 32'd0);
  endtask

  task automatic t_first_byte();
    rst_n = 1'b1;
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      chk(pop_valid == 1'b0, "R8 no byte before latency", 32'(pop_valid), 32'd0);
    end
    @(negedge clk);
    chk(pop_valid == 1'b1, "R8 first byte visible", 32'(pop_valid), 32'd1);
    chk(pop_data == code_at(16'h0000), "R8 first byte value", 32'(pop_data), 32'(code_at(16'h0000)));
  endtask

  task automatic t_full_stall();
    repeat (26) @(negedge clk);
    chk(mem_addr == 16'd6, "R2 address after six bytes", 32'(mem_addr), 32'd6);
    for (int i = 0; i < 10; i++) begin
      chk(mem_req == 1'b0, "R3 no request while full", 32'(mem_req), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_stream(input int first, input int n);
    for (int i = 0; i < n; i++) pop_expect(AW'(first + i), "R2 R9 byte order");
  endtask

  task automatic t_empty_pop(inout int nxt);
    while (pop_valid) begin
      pop_expect(AW'(nxt), "R2 drain");
      nxt++;
    end
    chk(pop_valid == 1'b0, "R4 queue empty", 32'(pop_valid), 32'd0);
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
    pop_expect(AW'(nxt), "R4 pop on empty ignored");
    nxt++;
  endtask

  task automatic t_redirect_inflight();
    while (!pop_valid) @(negedge clk);
    while (!mem_req) @(negedge clk);
    @(negedge clk);
    redirect = 1'b1;
    redirect_addr = 16'h1230;
    @(negedge clk);
    redirect = 1'b0;
    chk(pop_valid == 1'b0, "R5 queue flushed", 32'(pop_valid), 32'd0);
    chk(mem_addr == 16'h1230, "R5 target loaded", 32'(mem_addr), 32'h1230);
    pop_expect(16'h1230, "R6 target byte first");
    pop_expect(16'h1231, "R6 target plus one");
  endtask

  task automatic t_redirect_same_rvalid();
    @(negedge clk);
    #1;
    while (!mem_rvalid) begin
      @(negedge clk);
      #1;
    end
    redirect = 1'b1;
    redirect_addr = 16'h4A00;
    @(negedge clk);
    redirect = 1'b0;
    chk(pop_valid == 1'b0, "R6 returning byte dropped", 32'(pop_valid), 32'd0);
    chk(mem_addr == 16'h4A00, "R5 target loaded", 32'(mem_addr), 32'h4A00);
    pop_expect(16'h4A00, "R6 first byte after redirect");
  endtask

  task automatic t_pop_with_redirect();
    while (!pop_valid) @(negedge clk);
    pop_ready = 1'b1;
    redirect = 1'b1;
    redirect_addr = 16'h0F0F;
    @(negedge clk);
    pop_ready = 1'b0;
    redirect = 1'b0;
    chk(pop_valid == 1'b0, "R7 flush wins over pop", 32'(pop_valid), 32'd0);
    pop_expect(16'h0F0F, "R7 target byte kept");
    pop_expect(16'h0F10, "R7 sequence after target");
  endtask

  task automatic t_redirect_full();
    repeat (40) @(negedge clk);
    chk(mem_req == 1'b0, "R3 idle when full", 32'(mem_req), 32'd0);
    redirect = 1'b1;
    redirect_addr = 16'h2000;
    @(negedge clk);
    redirect = 1'b0;
    chk(pop_valid == 1'b0, "R5 full queue flushed", 32'(pop_valid), 32'd0);
    chk(mem_addr == 16'h2000, "R5 target from full", 32'(mem_addr), 32'h2000);
    pop_expect(16'h2000, "R6 byte after full redirect");
  endtask

  initial begin
    int nxt;
    rst_n = 1'b0;
    pop_ready = 1'b0;
    redirect = 1'b0;
    redirect_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_byte();
    t_full_stall();
    t_stream(0, 12);
    nxt = 12;
    t_empty_pop(nxt);
    t_redirect_inflight();
    t_redirect_same_rvalid();
    t_pop_with_redirect();
    t_redirect_full();
    summary();
    $finish;
  end
endmodule